// File: doc/BRIEF.md
# Loopback Echo Self-Test Checker

This block watches a serial bus transmitter check itself. Each word the encoder sends is recorded as the expected echo. The decoder's copy of that word, read back from the bus, is then checked against it. Every echo must arrive on time and must look like a well-formed word: correct sync, clean encoding, the right number of bits, odd parity, and the same sync type that was sent. Only the echo of the final word of a message is also compared bit by bit with the transmitted data. A transmitter watchdog timeout anywhere in the message also counts as a failure.

The message sequencer does three things. It pulses `msg_start` when a message begins. It flags the final word with `tx_last`. It pulses `eom` when the message is over. At `eom` the block updates `loop_fail`, which is meant to be copied into that message's status word, and it raises a one-cycle interrupt request when interrupts are enabled. The block expects at most one transmitted word to be awaiting its echo at any time.

Top module: `loopback_checker`

## Requirements
- R1: An echo that arrives while a word is awaited fails the message when any of `rx_sync_ok`, `rx_enc_ok` or `rx_bits_ok` is low.
- R2: An echo fails the message unless the XOR of its 16 data bits and `rx_parity` is 1 (odd parity, recomputed by the block).
- R3: An echo fails the message when `rx_cmd_sync` differs from the `tx_cmd_sync` of the awaited word.
- R4: The echo of a word sent with `tx_last`=1 fails the message when its data differs from the sent data. A data mismatch on any other word has no effect.
- R5: A word latched on a `tx_valid` edge must have its echo taken on one of the next ECHO_WIN (default 8) clock edges. Otherwise the message fails. A new `tx_valid` arriving while a word is still awaited, with no echo in that cycle, also fails the message.
- R6: `wdt_timeout` high on any edge of a message fails that message.
- R7: An `rx_valid` while no word is awaited fails the message.
- R8: `loop_fail` changes only on the edge that samples `eom`, taking the message's result. It holds that value until the next `eom`. Failures recorded before `msg_start` do not carry over into the new message.
- R9: `loop_irq` is high for exactly the one cycle after `eom`, and only when the message failed and `irq_en` was high with `eom`.
- R10: A failure sampled on the same edge as `eom` (a bad final echo, a watchdog timeout, or a word still awaited) counts toward that message.
- R11: After reset, `loop_fail` and `loop_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_start | input | 1 | Pulse at the first cycle of a message |
| tx_valid | input | 1 | A word is being encoded this cycle |
| tx_data | input | 16 | Data of the transmitted word |
| tx_cmd_sync | input | 1 | Sync type of the transmitted word (1 = command/status sync) |
| tx_last | input | 1 | The transmitted word is the message's last |
| rx_valid | input | 1 | The decoder delivers a received word |
| rx_data | input | 16 | Received data bits |
| rx_parity | input | 1 | Received parity bit |
| rx_cmd_sync | input | 1 | Received sync type |
| rx_sync_ok | input | 1 | Decoder saw a legal sync |
| rx_enc_ok | input | 1 | Decoder saw no encoding error |
| rx_bits_ok | input | 1 | Decoder counted the right number of bits |
| eom | input | 1 | End-of-message strobe |
| wdt_timeout | input | 1 | Transmitter watchdog expired |
| irq_en | input | 1 | Interrupt enable for loopback failures |
| loop_fail | output | 1 | Loopback result of the last completed message |
| loop_irq | output | 1 | One-cycle interrupt request |

## Verification
Two events can land on the same edge as the end-of-message strobe: an error detected that cycle, or a watchdog timeout. The bench drives `eom` in the same cycle as the final word's corrupted echo, in the same cycle as `wdt_timeout`, and in the same cycle as a still-awaited word. In each case it expects `loop_fail` and the interrupt one cycle later. It also drives a new transmit on the same edge as the previous word's echo, and expects that case to pass.

// File: rtl/loopchk_pkg.sv
// Package: shared types for the loopback echo checker.
// Assumes: decoder flags are active-high "good" indications.
package loopchk_pkg;

    // Decoder validity flags for one received word.
    typedef struct packed {
        logic sync_ok;
        logic enc_ok;
        logic bits_ok;
    } rx_flags_t;

endpackage

// File: rtl/loopchk_echo_judge.sv
// Echo judge: decides whether one received echo is unacceptable.
// Checks the decoder flags, odd parity over data plus parity bit, and the
// sync type. Compares data only for the message's final word.
// Assumes: chk_en is high only when an echo meets an awaited word.
module loopchk_echo_judge
    import loopchk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              chk_en,
    input  logic [DATA_W-1:0] exp_data,
    input  logic              exp_cmd,
    input  logic              exp_last,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              rx_cmd,
    input  rx_flags_t         rx_flags,
    output logic              word_bad
);

    logic flags_bad;
    logic par_bad;
    logic sync_bad;
    logic data_bad;

    // Combine the individual echo defects into one verdict.
    always_comb begin
        flags_bad = !(rx_flags.sync_ok && rx_flags.enc_ok && rx_flags.bits_ok);
        par_bad   = !(^{rx_data, rx_par});
        sync_bad  = (rx_cmd != exp_cmd);
        data_bad  = exp_last && (rx_data != exp_data);
        word_bad  = chk_en && (flags_bad || par_bad || sync_bad || data_bad);
    end

    // Guard the final-word compare and the parity rule.
    always_comb begin
        if (chk_en && exp_last && (rx_data != exp_data))
            assert_last_mismatch_R4: assert (word_bad);
        if (chk_en && !(^{rx_data, rx_par}))
            assert_even_parity_R2: assert (word_bad);
    end

endmodule

// File: rtl/loopchk_echo_track.sv
// Echo tracker: holds the one word awaiting its echo and times the echo
// window. Reports a missing echo (window expiry or overrun by a new word)
// and a stray echo (none awaited).
// Assumes: at most one word is outstanding at a time.
module loopchk_echo_track #(
    parameter int DATA_W   = 16,
    parameter int ECHO_WIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_cmd,
    input  logic              tx_last,
    input  logic              rx_valid,
    output logic              pending,
    output logic [DATA_W-1:0] exp_data,
    output logic              exp_cmd,
    output logic              exp_last,
    output logic              miss,
    output logic              stray
);

    localparam int CNT_W = $clog2(ECHO_WIN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ECHO_WIN - 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             expire;

    // Detect window expiry, overrun and stray echoes.
    always_comb begin
        expire = pending && !rx_valid && (wait_cnt == LAST_CNT);
        miss   = expire || (tx_valid && pending && !rx_valid);
        stray  = rx_valid && !pending;
    end

    // Load the expected word, retire it on echo, clear or expiry, count wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            wait_cnt <= '0;
            exp_data <= '0;
            exp_cmd  <= 1'b0;
            exp_last <= 1'b0;
        end else if (tx_valid) begin
            pending  <= 1'b1;
            wait_cnt <= '0;
            exp_data <= tx_data;
            exp_cmd  <= tx_cmd;
            exp_last <= tx_last;
        end else if (clear || rx_valid || expire) begin
            pending  <= 1'b0;
            wait_cnt <= '0;
        end else if (pending) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= LAST_CNT);
    assert_load_awaits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> pending);

endmodule

// File: rtl/loopchk_status.sv
// Status keeper: gathers failure events over a message and publishes the
// result and the interrupt pulse at end of message.
// Assumes: msg_start and eom are single-cycle strobes.
module loopchk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_start,
    input  logic eom,
    input  logic irq_en,
    input  logic fail_evt,
    output logic loop_fail,
    output logic loop_irq
);

    logic acc;
    logic hit;

    // Message verdict including this cycle's events.
    always_comb hit = acc || fail_evt;

    // Accumulate failures, restart on msg_start, empty after eom.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= 1'b0;
        else if (msg_start) acc <= fail_evt;
        else if (eom)       acc <= 1'b0;
        else                acc <= hit;
    end

    // Latch the status bit and issue the interrupt pulse at eom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_fail <= 1'b0;
            loop_irq  <= 1'b0;
        end else begin
            if (eom) loop_fail <= hit;
            loop_irq <= eom && irq_en && hit;
        end
    end

    assert_irq_after_eom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_irq |-> ($past(eom) && $past(irq_en) && loop_fail));
    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !eom |=> $stable(loop_fail));
    assert_wdt_at_eom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eom && fail_evt) |=> loop_fail);

endmodule

// File: rtl/loopback_checker.sv
// Loopback echo self-test checker top. Tracks the awaited echo, judges each
// echo, folds in watchdog timeouts and unfinished words at eom, and drives
// the per-message fail status and the interrupt request.
// Assumes: one word outstanding at a time; synchronous active-low reset.
module loopback_checker
    import loopchk_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ECHO_WIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_cmd_sync,
    input  logic              tx_last,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_parity,
    input  logic              rx_cmd_sync,
    input  logic              rx_sync_ok,
    input  logic              rx_enc_ok,
    input  logic              rx_bits_ok,
    input  logic              eom,
    input  logic              wdt_timeout,
    input  logic              irq_en,
    output logic              loop_fail,
    output logic              loop_irq
);

    logic              pending;
    logic [DATA_W-1:0] exp_data;
    logic              exp_cmd;
    logic              exp_last;
    logic              miss;
    logic              stray;
    logic              word_bad;
    logic              fail_evt;
    rx_flags_t         rx_flags;

    // Bundle decoder flags.
    always_comb rx_flags = '{sync_ok: rx_sync_ok, enc_ok: rx_enc_ok, bits_ok: rx_bits_ok};

    loopchk_echo_track #(.DATA_W(DATA_W), .ECHO_WIN(ECHO_WIN)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (msg_start),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_cmd   (tx_cmd_sync),
        .tx_last  (tx_last),
        .rx_valid (rx_valid),
        .pending  (pending),
        .exp_data (exp_data),
        .exp_cmd  (exp_cmd),
        .exp_last (exp_last),
        .miss     (miss),
        .stray    (stray)
    );

    loopchk_echo_judge #(.DATA_W(DATA_W)) u_judge (
        .chk_en   (rx_valid && pending),
        .exp_data (exp_data),
        .exp_cmd  (exp_cmd),
        .exp_last (exp_last),
        .rx_data  (rx_data),
        .rx_par   (rx_parity),
        .rx_cmd   (rx_cmd_sync),
        .rx_flags (rx_flags),
        .word_bad (word_bad)
    );

    // Any failure event seen this cycle.
    always_comb fail_evt = word_bad || miss || stray || wdt_timeout
                           || (eom && pending && !rx_valid);

    loopchk_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .eom       (eom),
        .irq_en    (irq_en),
        .fail_evt  (fail_evt),
        .loop_fail (loop_fail),
        .loop_irq  (loop_irq)
    );

    assert_stray_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eom && rx_valid && !pending) |=> loop_fail);

endmodule

// File: tb/test_loopback_checker.sv
module test_loopback_checker;

    localparam int DW  = 16;
    localparam int WIN = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic msg_start, tx_valid, tx_cmd_sync, tx_last;
    logic [DW-1:0] tx_data, rx_data;
    logic rx_valid, rx_parity, rx_cmd_sync, rx_sync_ok, rx_enc_ok, rx_bits_ok;
    logic eom, wdt_timeout, irq_en;
    logic loop_fail, loop_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    loopback_checker #(.DATA_W(DW), .ECHO_WIN(WIN)) i_loopback_checker (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_cmd_sync(tx_cmd_sync), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity(rx_parity),
        .rx_cmd_sync(rx_cmd_sync), .rx_sync_ok(rx_sync_ok), .rx_enc_ok(rx_enc_ok),
        .rx_bits_ok(rx_bits_ok), .eom(eom), .wdt_timeout(wdt_timeout),
        .irq_en(irq_en), .loop_fail(loop_fail), .loop_irq(loop_irq)
    );

    // Vector: {fault[3:0], irq enable, expected fail}
    // faults: 0 none, 1 sync flag, 2 encoding, 3 bit count, 4 parity, 5 sync type,
    // 6 last-word data, 7 non-last data, 8 missing echo, 9 watchdog, 10 stray
    localparam logic [5:0] VEC [0:11] = '{
        {4'd0, 1'b1, 1'b0}, {4'd1, 1'b1, 1'b1}, {4'd2, 1'b0, 1'b1},
        {4'd3, 1'b1, 1'b1}, {4'd4, 1'b1, 1'b1}, {4'd5, 1'b1, 1'b1},
        {4'd6, 1'b1, 1'b1}, {4'd7, 1'b1, 1'b0}, {4'd8, 1'b1, 1'b1},
        {4'd9, 1'b0, 1'b1}, {4'd10, 1'b1, 1'b1}, {4'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        msg_start = 0; tx_valid = 0; tx_data = '0; tx_cmd_sync = 0; tx_last = 0;
        rx_valid = 0; rx_data = '0; rx_parity = 0; rx_cmd_sync = 0;
        rx_sync_ok = 0; rx_enc_ok = 0; rx_bits_ok = 0; eom = 0; wdt_timeout = 0;
    endtask

    task automatic step();
        @(negedge clk);
        quiet();
    endtask

    task automatic drive_tx(input logic [DW-1:0] d, input logic c, input logic l);
        tx_valid = 1; tx_data = d; tx_cmd_sync = c; tx_last = l;
    endtask

    task automatic drive_rx(input logic [DW-1:0] d, input logic c, input int fault);
        rx_valid = 1; rx_data = d; rx_cmd_sync = c; rx_parity = ~^d;
        rx_sync_ok = (fault != 1); rx_enc_ok = (fault != 2); rx_bits_ok = (fault != 3);
        if (fault == 4) rx_parity = ^d;
        if (fault == 5) rx_cmd_sync = ~c;
    endtask

    task automatic finish_check(input string req, input logic ef, input logic ei);
        eom = 1; step();
        check({req, " loop_fail"}, loop_fail, ef);
        check({req, " loop_irq"}, loop_irq, ei);
        step();
        check({req, " irq one cycle"}, loop_irq, 0);
    endtask

    task automatic run_msg(input int fault, input logic en, input logic ef);
        msg_start = 1; step();
        for (int w = 0; w < 3; w++) begin
            logic [DW-1:0] d;
            logic c;
            int f;
            d = 16'hA5C3 ^ DW'(w * 16'h1111);
            c = (w == 0);
            f = 0;
            if (fault >= 1 && fault <= 5 && w == 1) f = fault;
            drive_tx(d, c, w == 2); step();
            step();
            if (fault == 8 && w == 1) begin
                repeat (WIN) step();
            end else begin
                if (fault == 6 && w == 2) d = d ^ 16'h0100;
                if (fault == 7 && w == 0) d = d ^ 16'h0001;
                drive_rx(d, c, f); step();
            end
            if (fault == 9 && w == 1) begin wdt_timeout = 1; step(); end
        end
        if (fault == 10) begin drive_rx(16'h0, 0, 0); step(); end
        irq_en = en;
        finish_check($sformatf("R1 R2 R3 R4 R5 R6 R7 R9 vector fault=%0d", fault), ef, ef & en);
    endtask

    // One-word message with echo after k edges.
    task automatic one_word(input int k, input logic ef, input string req);
        msg_start = 1; step();
        drive_tx(16'h3C5A, 0, 1); step();
        repeat (k - 1) step();
        drive_rx(16'h3C5A, 0, 0); step();
        irq_en = 1;
        finish_check(req, ef, ef);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        quiet(); irq_en = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        check("R11 loop_fail after reset", loop_fail, 0);
        check("R11 loop_irq after reset", loop_irq, 0);
        rst_n = 1;
        step();

        for (int i = 0; i < 12; i++) begin
            run_msg(int'(VEC[i][5:2]), VEC[i][1], VEC[i][0]);
        end

        // R5 window boundary
        one_word(WIN, 0, "R5 echo at last allowed edge");
        one_word(WIN + 1, 1, "R5 echo one edge late");

        // R10 bad last echo on the eom edge
        msg_start = 1; step();
        drive_tx(16'h1234, 1, 1); step();
        drive_rx(16'h1235, 1, 0); eom = 1; irq_en = 1; step();
        check("R10 bad last echo with eom", loop_fail, 1);
        check("R10 irq with eom", loop_irq, 1);
        step();

        // R8 clean message clears status
        one_word(2, 0, "R8 clean message after fail");

        // R10 watchdog on the eom edge
        msg_start = 1; step();
        drive_tx(16'h0F0F, 0, 1); step();
        drive_rx(16'h0F0F, 0, 0); step();
        wdt_timeout = 1; eom = 1; step();
        check("R10 watchdog with eom", loop_fail, 1);
        // R8 hold across idle cycles
        repeat (5) step();
        check("R8 status held until next eom", loop_fail, 1);

        // R10 word still awaited at eom
        msg_start = 1; step();
        drive_tx(16'h0F0F, 0, 1); step();
        eom = 1; step();
        check("R10 awaited word at eom", loop_fail, 1);

        // R5 new transmit on same edge as previous echo passes; R8 start clears
        msg_start = 1; step();
        drive_tx(16'h1111, 0, 0); step();
        drive_tx(16'h2222, 0, 1); drive_rx(16'h1111, 0, 0); step();
        drive_rx(16'h2222, 0, 0); step();
        irq_en = 0;
        finish_check("R5 R8 back-to-back echo and transmit", 0, 0);

        // R4 last-word mismatch with irq disabled
        msg_start = 1; step();
        drive_tx(16'h8001, 0, 1); step();
        drive_rx(16'h8000, 0, 0); rx_parity = 0; step();
        irq_en = 0;
        finish_check("R4 R9 last mismatch irq disabled", 1, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule